// File: doc/BRIEF.md
# Boot Remap Address Decoder

This block turns a 32-bit bus request address into a one-hot region select and an external chip-select vector. The regions are on-chip boot ROM, on-chip RAM and the external banks. The external banks are three static banks of 4 MB each and four dynamic banks of 8 MB each. Decoding is combinational: the selects follow the request inputs in the same cycle that the request is valid. An out-of-map address raises an error flag and drives no select.

The low window starting at address zero is an alias, and its target depends on the boot phase.
- Before remap, a boot-select pin points the window either at the boot ROM or at external flash on static bank 0.
- Once software sets the remap bit, the window points at the 8 KB internal RAM. The bit cannot be cleared again until reset.

Each external bank carries a programmable access width. The block reports the width of the selected bank to a downstream access sequencer.

Top module: `bootRemapDecoder`

## Requirements
- R1: After reset the remap bit is 0 and every bank width field holds 32-bit (encoding 10).
- R2: With remap 0 and bootSel 0, addresses 0x0 to 0x3FFF select the boot ROM (regionSel bit 0).
- R3: With remap 0 and bootSel 1, addresses 0x0 to 0x3F_FFFF select external memory (regionSel bit 2) with chipSel bit 0 and the width of bank 0.
- R4: With remap 1, addresses 0x0 to 0x1FFF select internal RAM (regionSel bit 1), whatever bootSel is, and 0x2000 and above in the old alias window are errors.
- R5: Static bank i (i = 0..2) answers at 0x6000_0000 + i*0x40_0000 for 4 MB and drives chipSel bit i.
- R6: Dynamic bank j (j = 0..3) answers at 0x8000_0000 + j*0x80_0000 for 8 MB and drives chipSel bit 3+j.
- R7: Boot ROM at 0x4000_0000 (16 KB) and internal RAM at 0x4010_0000 (8 KB) are reachable in every mode.
- R8: A config write with cfgAddr 1 loads bank k's width from cfgWrData[2k+1:2k] (banks 0..6 in chipSel order). busWidth reports 00 for 8-bit, 01 for 16-bit and 10 for 32-bit, reports encoding 11 as 10, reports 10 for ROM and RAM, and reports 00 when nothing is selected.
- R9: A config write with cfgAddr 0 and cfgWrData[0]=1 sets remap from the next cycle. A write of 0 has no effect, so only reset clears remap.
- R10: An unmapped valid address sets addrErr with no selects, and with reqValid low all outputs are zero.
- R11: regionSel is one-hot or zero, with bit 0 for ROM, bit 1 for RAM and bit 2 for external memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bootSel | input | 1 | Boot source pin: 0 ROM, 1 external flash |
| reqValid | input | 1 | Request valid |
| reqAddr | input | 32 | Request byte address |
| cfgWrEn | input | 1 | Config register write strobe |
| cfgAddr | input | 1 | Config register: 0 remap, 1 bank widths |
| cfgWrData | input | 14 | Config write data |
| regionSel | output | 3 | One-hot region select |
| chipSel | output | 7 | External bank chip selects |
| busWidth | output | 2 | Access width of selected target |
| addrErr | output | 1 | Unmapped address flag |

## Verification
The bench probes both edges of every window in each of the three boot phases: the first byte, the last byte, and the byte just outside. A decoder with an off-by-one limit would select a neighbour or miss the error flag, and one with a wrong alias size would send 0x2000 or 0x4000 to the wrong target. The bench also tries to clear remap with a zero write and loads the reserved width code 11. A non-sticky remap would bring the ROM back at zero, and a raw width pass-through would report 11.

// File: rtl/brdPkg.sv
package brdPkg;
  localparam int NUM_STATIC = 3;
  localparam int NUM_DYN    = 4;
  localparam int NUM_BANKS  = NUM_STATIC + NUM_DYN;
  localparam int CFG_W      = 2 * NUM_BANKS;

  localparam int REG_ROM = 0;
  localparam int REG_RAM = 1;
  localparam int REG_EXT = 2;

  localparam logic [1:0] WID_8  = 2'b00;
  localparam logic [1:0] WID_16 = 2'b01;
  localparam logic [1:0] WID_32 = 2'b10;

  typedef struct packed {
    logic                         remapOn;
    logic                         flashBoot;
    logic [NUM_BANKS-1:0][1:0]    bankWidth;
  } ctrlStrobes_t;

  function automatic logic [1:0] normWidth(input logic [1:0] code);
    return (code == 2'b11) ? WID_32 : code;
  endfunction
endpackage

// File: rtl/brdControl.sv
module brdControl
  import brdPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bootSel,
  input  logic             cfgWrEn,
  input  logic             cfgAddr,
  input  logic [CFG_W-1:0] cfgWrData,
  output ctrlStrobes_t     ctrl
);
  logic                      remapQ;
  logic [NUM_BANKS-1:0][1:0] widthQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remapQ <= 1'b0;
      widthQ <= {NUM_BANKS{WID_32}};
    end else if (cfgWrEn) begin
      if (!cfgAddr) remapQ <= remapQ | cfgWrData[0];
      else          widthQ <= cfgWrData;
    end
  end

  always_comb begin
    ctrl.remapOn   = remapQ;
    ctrl.flashBoot = bootSel;
    ctrl.bankWidth = widthQ;
  end

  p_remap_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    remapQ |=> remapQ);
  p_remap_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgAddr && cfgWrData[0]) |=> remapQ);
  p_width_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr) |=> (widthQ == $past(cfgWrData)));
endmodule

// File: rtl/brdDatapath.sv
module brdDatapath
  import brdPkg::*;
#(
  parameter logic [31:0] ROM_BASE     = 32'h4000_0000,
  parameter logic [31:0] ROM_BYTES    = 32'h0000_4000,
  parameter logic [31:0] RAM_BASE     = 32'h4010_0000,
  parameter logic [31:0] RAM_BYTES    = 32'h0000_2000,
  parameter logic [31:0] STATIC_BASE  = 32'h6000_0000,
  parameter logic [31:0] STATIC_BYTES = 32'h0040_0000,
  parameter logic [31:0] DYN_BASE     = 32'h8000_0000,
  parameter logic [31:0] DYN_BYTES    = 32'h0080_0000
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         ctrl,
  input  logic                 reqValid,
  input  logic [31:0]          reqAddr,
  output logic [2:0]           regionSel,
  output logic [NUM_BANKS-1:0] chipSel,
  output logic [1:0]           busWidth,
  output logic                 addrErr
);
  logic [2:0]           hitRegion;
  logic [NUM_BANKS-1:0] hitBank;

  always_comb begin
    hitRegion = '0;
    hitBank   = '0;
    if (reqAddr >= ROM_BASE && reqAddr < ROM_BASE + ROM_BYTES) hitRegion[REG_ROM] = 1'b1;
    if (reqAddr >= RAM_BASE && reqAddr < RAM_BASE + RAM_BYTES) hitRegion[REG_RAM] = 1'b1;
    for (int i = 0; i < NUM_STATIC; i++) begin
      if (reqAddr >= STATIC_BASE + 32'(i) * STATIC_BYTES &&
          reqAddr <  STATIC_BASE + 32'(i + 1) * STATIC_BYTES) hitBank[i] = 1'b1;
    end
    for (int j = 0; j < NUM_DYN; j++) begin
      if (reqAddr >= DYN_BASE + 32'(j) * DYN_BYTES &&
          reqAddr <  DYN_BASE + 32'(j + 1) * DYN_BYTES) hitBank[NUM_STATIC + j] = 1'b1;
    end
    if (ctrl.remapOn) begin
      if (reqAddr < RAM_BYTES) hitRegion[REG_RAM] = 1'b1;
    end else if (ctrl.flashBoot) begin
      if (reqAddr < STATIC_BYTES) hitBank[0] = 1'b1;
    end else begin
      if (reqAddr < ROM_BYTES) hitRegion[REG_ROM] = 1'b1;
    end
    hitRegion[REG_EXT] = |hitBank;
  end

  always_comb begin
    regionSel = '0;
    chipSel   = '0;
    busWidth  = '0;
    addrErr   = 1'b0;
    if (reqValid) begin
      regionSel = hitRegion;
      chipSel   = hitBank;
      addrErr   = (hitRegion == '0);
      if (hitRegion[REG_ROM] || hitRegion[REG_RAM]) busWidth = WID_32;
      for (int k = 0; k < NUM_BANKS; k++) begin
        if (hitBank[k]) busWidth = normWidth(ctrl.bankWidth[k]);
      end
    end
  end

  p_region_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regionSel));
  p_err_nosel_r10: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> (regionSel == '0 && chipSel == '0));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (regionSel == '0 && chipSel == '0 && !addrErr && busWidth == '0));
  p_ext_cs_r5: assert property (@(posedge clk) disable iff (!rstN)
    regionSel[REG_EXT] |-> $onehot(chipSel));
  p_alias_ram_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ctrl.remapOn && reqAddr < RAM_BYTES) |-> regionSel[REG_RAM]);
  p_width_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    busWidth != 2'b11);
endmodule

// File: rtl/bootRemapDecoder.sv
module bootRemapDecoder
  import brdPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bootSel,
  input  logic             reqValid,
  input  logic [31:0]      reqAddr,
  input  logic             cfgWrEn,
  input  logic             cfgAddr,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [2:0]       regionSel,
  output logic [6:0]       chipSel,
  output logic [1:0]       busWidth,
  output logic             addrErr
);
  ctrlStrobes_t ctrl;

  brdControl i_ctrl (
    .clk(clk), .rstN(rstN), .bootSel(bootSel), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .ctrl(ctrl)
  );

  brdDatapath i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqValid(reqValid), .reqAddr(reqAddr),
    .regionSel(regionSel), .chipSel(chipSel), .busWidth(busWidth), .addrErr(addrErr)
  );
endmodule

// File: tb/test_bootRemapDecoder.sv
module test_bootRemapDecoder;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bootSel = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        cfgWrEn = 1'b0;
  logic        cfgAddr = 1'b0;
  logic [13:0] cfgWrData = '0;
  logic [2:0]  regionSel;
  logic [6:0]  chipSel;
  logic [1:0]  busWidth;
  logic        addrErr;

  int checks = 0;
  int fails  = 0;
  logic       mRemap = 1'b0;
  logic [1:0] mWidth [7];

  bootRemapDecoder i_bootRemapDecoder (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic cfgWrite(input logic a, input logic [13:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, input string req);
    logic [2:0] eReg; logic [6:0] eCs; logic [1:0] eW; logic eErr; logic [31:0] off;
    eReg = '0; eCs = '0;
    if (a >= 32'h4000_0000 && a < 32'h4000_4000) eReg = 3'b001;
    if (a >= 32'h4010_0000 && a < 32'h4010_2000) eReg = 3'b010;
    if (a >= 32'h6000_0000 && a < 32'h6000_0000 + 3 * 32'h40_0000) begin
      off = (a - 32'h6000_0000) / 32'h40_0000; eCs[off] = 1'b1;
    end
    if (a >= 32'h8000_0000 && a < 32'h8000_0000 + 4 * 32'h80_0000) begin
      off = (a - 32'h8000_0000) / 32'h80_0000; eCs[3 + off] = 1'b1;
    end
    if (mRemap) begin if (a < 32'h2000) eReg = 3'b010; end
    else if (bootSel) begin if (a < 32'h40_0000) eCs[0] = 1'b1; end
    else if (a < 32'h4000) eReg = 3'b001;
    if (eCs != 0) eReg = 3'b100;
    eW = 2'b00;
    if (eReg[0] || eReg[1]) eW = 2'b10;
    for (int k = 0; k < 7; k++) if (eCs[k]) eW = (mWidth[k] == 2'b11) ? 2'b10 : mWidth[k];
    eErr = (eReg == 0);
    reqValid = 1'b1; reqAddr = a;
    #1;
    checks++;
    if (regionSel !== eReg || chipSel !== eCs || busWidth !== eW || addrErr !== eErr) begin
      fails++;
      $display("FAIL %s addr=%h got reg=%b cs=%b w=%b err=%b exp reg=%b cs=%b w=%b err=%b",
               req, a, regionSel, chipSel, busWidth, addrErr, eReg, eCs, eW, eErr);
    end
  endtask

  task automatic sweep(input string req);
    logic [31:0] a;
    probe(32'h0, req); probe(32'h1FFF, req); probe(32'h2000, req);
    probe(32'h3FFF, req); probe(32'h4000, req); probe(32'h3F_FFFF, req);
    probe(32'h40_0000, req); probe(32'h3FFF_FFFF, req);
    probe(32'h4000_0000, "R7"); probe(32'h4000_3FFF, "R7"); probe(32'h4000_4000, "R7");
    probe(32'h4010_0000, "R7"); probe(32'h4010_1FFF, "R7"); probe(32'h4010_2000, "R7");
    for (int i = 0; i <= 3; i++) begin
      a = 32'h6000_0000 + 32'(i) * 32'h40_0000;
      probe(a, "R5"); probe(a - 1, "R5");
    end
    for (int j = 0; j <= 4; j++) begin
      a = 32'h8000_0000 + 32'(j) * 32'h80_0000;
      probe(a, "R6"); probe(a - 1, "R6");
    end
    probe(32'hFFFF_FFFF, "R10");
    reqValid = 1'b0; reqAddr = 32'h6000_0000; #1;
    checks++;
    if (regionSel !== 0 || chipSel !== 0 || busWidth !== 0 || addrErr !== 0) begin
      fails++;
      $display("FAIL R10 idle got reg=%b cs=%b w=%b err=%b exp all zero",
               regionSel, chipSel, busWidth, addrErr);
    end
  endtask

  initial begin
    for (int k = 0; k < 7; k++) mWidth[k] = 2'b10;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset widths 32-bit and remap 0 seen at ports
    probe(32'h6000_0000, "R1");
    probe(32'h8180_0000, "R1");
    probe(32'h0, "R1");
    sweep("R2");
    bootSel = 1'b1;
    sweep("R3");
    // R8: widths 0,1,2,3,0,1,2 for banks 0..6
    cfgWrite(1'b1, 14'b10_01_00_11_10_01_00);
    for (int k = 0; k < 7; k++) mWidth[k] = 2'(k % 4);
    for (int k = 0; k < 3; k++) probe(32'h6000_0000 + 32'(k) * 32'h40_0000, "R8");
    for (int k = 0; k < 4; k++) probe(32'h8000_0000 + 32'(k) * 32'h80_0000, "R8");
    probe(32'h10, "R8");
    // R9: writing 0 to remap has no effect
    cfgWrite(1'b0, 14'h0);
    probe(32'h0, "R9");
    cfgWrite(1'b0, 14'h1);
    mRemap = 1'b1;
    sweep("R4");
    bootSel = 1'b0;
    sweep("R4");
    cfgWrite(1'b0, 14'h0);
    probe(32'h0, "R9");
    probe(32'h1000, "R9");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule